// File: doc/BRIEF.md
# Packed Two-Digit Decimal to Binary Converter

This block turns an eight-bit packed decimal value, made of two four-bit digits, into a seven-bit unsigned binary number. It has no clock and no state: the result follows the input within the same cycle. Bits 7:4 of the input hold the tens digit and bits 3:0 hold the units digit.

The conversion does not multiply the tens digit by ten. Each input bit is given a fixed binary constant equal to its decimal weight: 1, 2, 4 and 8 for the units digit, and 10, 20, 40 and 80 for the tens digit. Each constant passes only when its bit is 1. A balanced adder tree then adds the constants that passed. A separate per-digit check raises a flag when either digit holds one of the six codes above nine. An enable input qualifies the input code. While the enable is low, both outputs are held at zero.

Top module: `bcd_to_bin_conv`

## Requirements
- R1: Bits 3:0 form the units digit, and its bits 0, 1, 2 and 3 add 1, 2, 4 and 8 to the result.
- R2: Bits 7:4 form the tens digit, and its bits 4, 5, 6 and 7 add 10, 20, 40 and 80 to the result.
- R3: With `code_vld` high, `bin_out` equals the sum of the weights of the set input bits and of no other bits. For every legal code this is tens*10 + units.
- R4: Code 8'b0100_0110 gives 7'b0101110 (46), and code 8'b0010_0110 gives 7'b0011010 (26).
- R5: With `code_vld` high, `bad_code` is 1 exactly when the tens digit or the units digit is in the range 4'b1010 to 4'b1111. Otherwise it is 0.
- R6: When a digit is illegal, `bin_out` still carries the weighted sum, taken modulo 128 (for example 8'hFF gives 165 mod 128 = 37).
- R7: With `code_vld` low, `bin_out` is 0 and `bad_code` is 0, whatever the code.
- R8: For every legal code the full-width sum is at most 99, so seven output bits hold it and no carry out exists.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| code_vld | input | 1 | Qualifies `code_in`. When it is low, both outputs are zero |
| code_in | input | 8 | Packed decimal code: tens digit in [7:4], units digit in [3:0] |
| bin_out | output | 7 | Binary value of the code |
| bad_code | output | 1 | High when either digit is above nine |

## Verification
The bench builds the converter with its default widths: 4-bit digits, an 8-bit internal accumulator and a 7-bit result. With these widths the whole input space has only 256 codes, so the bench applies every one of them, both legal and illegal. Running all illegal codes brings the accumulator's wrap past 127 into reach, along with the flag on each of the six forbidden values in each digit position. Single-bit codes isolate each weight constant, and holding the enable low over all-ones shows that the gating has priority.

// File: rtl/bcd_bin_pkg.sv
package bcd_bin_pkg;

    localparam int DIGIT_W  = 4;
    localparam int N_DIGITS = 2;
    localparam int CODE_W   = DIGIT_W * N_DIGITS;
    localparam int BIN_W    = 7;
    localparam int ACC_W    = 8;
    localparam int MAX_DIG  = 9;

    typedef logic [DIGIT_W-1:0] digit_t;

    typedef struct packed {
        digit_t tens;
        digit_t units;
    } code_pair_t;

    // Decimal weight of packed-code bit idx: 10^(digit) * 2^(bit in digit)
    function automatic int bit_weight(input int idx);
        int scale;
        scale = 1;
        for (int d = 0; d < idx / DIGIT_W; d++) begin
            scale = scale * 10;
        end
        return scale * (1 << (idx % DIGIT_W));
    endfunction

endpackage

// File: rtl/bcd_digit_check.sv
module bcd_digit_check
    import bcd_bin_pkg::*;
#(
    parameter int DW   = DIGIT_W,
    parameter int LIMIT = MAX_DIG
) (
    input  logic [DW-1:0] digit,
    output logic          over
);
    always_comb begin
        over = (int'(digit) > LIMIT);
    end
endmodule

// File: rtl/bcd_weight_gate.sv
module bcd_weight_gate
    import bcd_bin_pkg::*;
#(
    parameter int NB = CODE_W,
    parameter int AW = ACC_W
) (
    input  logic [NB-1:0]         bits_in,
    output logic [NB-1:0][AW-1:0] terms
);
    for (genvar i = 0; i < NB; i++) begin : g_term
        localparam logic [AW-1:0] WEIGHT = AW'(bit_weight(i));
        assign terms[i] = bits_in[i] ? WEIGHT : '0;
    end
endmodule

// File: rtl/bcd_adder_tree.sv
module bcd_adder_tree
    import bcd_bin_pkg::*;
#(
    parameter int N_TERMS = CODE_W,
    parameter int AW      = ACC_W
) (
    input  logic [N_TERMS-1:0][AW-1:0] terms,
    output logic [AW-1:0]              sum
);
    localparam int LEVELS = (N_TERMS <= 1) ? 0 : $clog2(N_TERMS);
    localparam int LEAVES = 1 << LEVELS;
    localparam int NODES  = 2 * LEAVES - 1;

    logic [AW-1:0] node [NODES];

    for (genvar k = 0; k < LEAVES; k++) begin : g_leaf
        if (k < N_TERMS) begin : g_used
            assign node[LEAVES-1+k] = terms[k];
        end else begin : g_pad
            assign node[LEAVES-1+k] = '0;
        end
    end

    for (genvar n = 0; n < LEAVES - 1; n++) begin : g_node
        assign node[n] = node[2*n+1] + node[2*n+2];
    end

    assign sum = node[0];
endmodule

// File: rtl/bcd_to_bin_conv.sv
module bcd_to_bin_conv
    import bcd_bin_pkg::*;
#(
    parameter int OUT_W = BIN_W,
    parameter int SUM_W = ACC_W
) (
    input  logic              code_vld,
    input  logic [CODE_W-1:0] code_in,
    output logic [OUT_W-1:0]  bin_out,
    output logic              bad_code
);
    code_pair_t                    pair;
    logic [N_DIGITS-1:0]           dig_over;
    logic [CODE_W-1:0][SUM_W-1:0]  terms;
    logic [SUM_W-1:0]              acc;

    assign pair = code_pair_t'(code_in);

    for (genvar d = 0; d < N_DIGITS; d++) begin : g_dig
        bcd_digit_check #(.DW(DIGIT_W), .LIMIT(MAX_DIG)) u_chk (
            .digit (code_in[d*DIGIT_W +: DIGIT_W]),
            .over  (dig_over[d])
        );
    end

    bcd_weight_gate #(.NB(CODE_W), .AW(SUM_W)) u_gate (
        .bits_in (code_in),
        .terms   (terms)
    );

    bcd_adder_tree #(.N_TERMS(CODE_W), .AW(SUM_W)) u_tree (
        .terms (terms),
        .sum   (acc)
    );

    always_comb begin
        bin_out  = code_vld ? acc[OUT_W-1:0] : '0;
        bad_code = code_vld & (|dig_over);
    end

    always_comb begin
        // R7: idle enable forces both outputs low
        if (!code_vld) begin
            a_r7_idle_zero: assert (bin_out == '0 && !bad_code);
        end
        // R8: a legal code never needs more than seven bits
        if (code_vld && !bad_code) begin
            a_r8_no_carry: assert (acc <= SUM_W'(99));
        end
        // R1: only the unit-weight bit is odd, so it fixes the result LSB
        if (code_vld) begin
            a_r1_lsb_parity: assert (bin_out[0] == code_in[0]);
        end
        // R2: with tens digit zero the result is the units digit itself
        if (code_vld && pair.tens == '0) begin
            a_r2_tens_absent: assert (bin_out == OUT_W'(pair.units));
        end
        // R5: flag only ever appears under a valid code
        if (bad_code) begin
            a_r5_flag_qualified: assert (code_vld);
        end
    end
endmodule

// File: tb/bcd_to_bin_conv_bench.sv
module bcd_to_bin_conv_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       code_vld;
    logic [7:0] code_in;
    logic [6:0] bin_out;
    logic       bad_code;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    bcd_to_bin_conv u_bcd_to_bin_conv (
        .code_vld (code_vld),
        .code_in  (code_in),
        .bin_out  (bin_out),
        .bad_code (bad_code)
    );

    task automatic apply(input logic v, input logic [7:0] c);
        @(posedge clk);
        code_vld = v;
        code_in  = c;
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [6:0] exp_bin, input logic exp_bad);
        n_checks++;
        if (bin_out !== exp_bin || bad_code !== exp_bad) begin
            n_fail++;
            $display("FAIL %s code=%02h vld=%0b: got bin=%0d bad=%0b, expected bin=%0d bad=%0b",
                     req, code_in, code_vld, bin_out, bad_code, exp_bin, exp_bad);
        end
    endtask

    // R7: idle enable at start
    task automatic t_idle();
        apply(1'b0, 8'h00);
        check("R7", 7'd0, 1'b0);
        apply(1'b0, 8'h99);
        check("R7", 7'd0, 1'b0);
    endtask

    // R1 and R2: isolate each bit weight
    task automatic t_single_bits();
        int w [8] = '{1, 2, 4, 8, 10, 20, 40, 80};
        for (int b = 0; b < 4; b++) begin
            apply(1'b1, 8'(1 << b));
            check("R1", 7'(w[b]), 1'b0);
        end
        for (int b = 4; b < 8; b++) begin
            apply(1'b1, 8'(1 << b));
            check("R2", 7'(w[b]), (b == 7) ? 1'b0 : 1'b0);
        end
    endtask

    // R3 and R8: every legal code
    task automatic t_legal_sweep();
        for (int t = 0; t < 10; t++) begin
            for (int u = 0; u < 10; u++) begin
                apply(1'b1, 8'((t << 4) | u));
                check((t == 9 && u == 9) ? "R8" : "R3", 7'(t * 10 + u), 1'b0);
            end
        end
    endtask

    // R4: worked examples
    task automatic t_examples();
        apply(1'b1, 8'b0100_0110);
        check("R4", 7'b0101110, 1'b0);
        apply(1'b1, 8'b0010_0110);
        check("R4", 7'b0011010, 1'b0);
    endtask

    // R5 and R6: every code with at least one forbidden digit
    task automatic t_forbidden();
        for (int t = 0; t < 16; t++) begin
            for (int u = 0; u < 16; u++) begin
                if (t > 9 || u > 9) begin
                    apply(1'b1, 8'((t << 4) | u));
                    check((t == 15 && u == 15) ? "R6" : "R5", 7'((t * 10 + u) % 128), 1'b1);
                end
            end
        end
    endtask

    // R7: enable low overrides a forbidden code
    task automatic t_gate_forbidden();
        apply(1'b0, 8'hFF);
        check("R7", 7'd0, 1'b0);
        apply(1'b1, 8'hFF);
        check("R6", 7'd37, 1'b1);
        apply(1'b0, 8'hA0);
        check("R7", 7'd0, 1'b0);
    endtask

    initial begin
        code_vld = 1'b0;
        code_in  = 8'h00;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        t_idle();
        t_single_bits();
        t_legal_sweep();
        t_examples();
        t_forbidden();
        t_gate_forbidden();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: got timeout, expected completion");
            end
        join_any
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule